// File: doc/BRIEF.md
# PRESENT Digest and Scramble Engine

This block turns a stream of 64-bit data beats into a 64-bit digest. An iterative PRESENT block cipher with a 128-bit key evaluates one round per clock. The cipher is wired as a Davies-Meyer compression step inside a Merkle-Damgard chain. The chaining value starts from a caller-supplied initial value. Every 128-bit chunk of input serves as the cipher key that encrypts the chaining value, and the result is XORed back onto that value. After the last chunk, one more keyed pass, using a caller-supplied finalization constant, produces the digest.

The same datapath also performs a plain scramble: a single 64-bit block is encrypted under a 128-bit key, with no feed-forward. One input selects the operation when the job starts. Two shared inputs carry the 64-bit block operand (the initial value for a digest, the plaintext for a scramble) and the 128-bit key operand (the finalization constant for a digest, the cipher key for a scramble). The result leaves on a held output register and is marked by a one-cycle done pulse.

Top module: `prst_digest`

## Requirements
- R1: A scramble job returns the PRESENT-128 ciphertext of `blk_i` under `key_i`. This is 31 rounds, each consisting of round-key addition, the 4-bit S-box on all 16 nibbles, and the bit permutation, followed by a final key addition. The key schedule rotates left by 61, substitutes the top two nibbles, and XORs the round number into key bits 66..62. An all-zero block under an all-zero key gives 64'h96db702a2e6900af.
- R2: `done_o` rises exactly 31 clock edges after the edge that accepts a scramble start. It is high for one cycle only. `digest_o` keeps its value while `done_o` is low.
- R3: A digest job loads the chaining value from `blk_i`. Each 128-bit chunk is built from two accepted beats, with the first beat as bits 63..0 and the second beat as bits 127..64. The chunk is the key K of the update chain = E_K(chain) XOR chain.
- R4: When `data_last_i` comes with the first beat of a chunk, the chunk is completed with 64 zero bits as its upper half. The result equals that of sending an explicit all-zero second beat.
- R5: After the chunk that carries `data_last_i`, the digest is E_C(chain) XOR chain, where C is the `key_i` value captured at start.
- R6: `data_ready_o` is high only while the engine waits for a beat. It is low during cipher rounds and while idle, and beats offered while it is low have no effect on the digest.
- R7: After reset, `done_o`, `data_ready_o` and `digest_o` are all zero.
- R8: `start_i` is ignored unless the engine is idle. A start pulse during a digest job does not change that job's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a job (accepted only when idle) |
| scramble_i | input | 1 | Job type at start: 1 = scramble, 0 = digest |
| blk_i | input | 64 | Initial chaining value (digest) or plaintext (scramble) |
| key_i | input | 128 | Finalization constant (digest) or cipher key (scramble) |
| data_i | input | 64 | Data beat |
| data_valid_i | input | 1 | Data beat offered |
| data_last_i | input | 1 | Offered beat is the last of the message |
| data_ready_o | output | 1 | Engine accepts a beat this cycle |
| digest_o | output | 64 | Result of the last completed job |
| done_o | output | 1 | One-cycle pulse when `digest_o` is updated |

## Verification
The bench aims at the half-chunk case. A design that padded on the wrong side, or waited for a second beat, would return a wrong digest or hang. It also checks the round count and the final key addition through the published all-zero vector, where an off-by-one round gives a different ciphertext and a shifted done pulse. Valid beats are held up during rounds and a stray start pulse is sent mid-message. A design that took either of them would silently corrupt the chain. Multi-chunk messages expose a missing feed-forward or a finalization pass run without it.

// File: rtl/prst_pkg.sv
package prst_pkg;

    localparam int BLK_W   = 64;
    localparam int KEY_W   = 128;
    localparam int NROUNDS = 31;
    localparam int RC_W    = 5;
    localparam int RC_LO   = 62;   // round counter is XORed into key bits RC_LO+RC_W-1..RC_LO
    localparam int NIB     = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_COLLECT,
        PH_RUN
    } phase_e;

    typedef enum logic [1:0] {
        JOB_SCRAMBLE,
        JOB_CHUNK,
        JOB_FINAL
    } job_e;

    function automatic logic [NIB-1:0] sbox4(input logic [NIB-1:0] x);
        logic [NIB-1:0] y;
        case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/prst_sbox_layer.sv
module prst_sbox_layer #(
    parameter int W = 64
) (
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int NNIB = W / prst_pkg::NIB;

    for (genvar g = 0; g < NNIB; g++) begin : g_nib
        assign q_o[g*prst_pkg::NIB +: prst_pkg::NIB] =
            prst_pkg::sbox4(d_i[g*prst_pkg::NIB +: prst_pkg::NIB]);
    end
endmodule

// File: rtl/prst_round.sv
module prst_round #(
    parameter int BLK_W = prst_pkg::BLK_W,
    parameter int KEY_W = prst_pkg::KEY_W,
    parameter int RC_W  = prst_pkg::RC_W,
    parameter int RC_LO = prst_pkg::RC_LO
) (
    input  logic [BLK_W-1:0] st_i,
    input  logic [KEY_W-1:0] rk_i,
    input  logic [RC_W-1:0]  rc_i,
    output logic [BLK_W-1:0] st_o,
    output logic [KEY_W-1:0] rk_o,
    output logic [BLK_W-1:0] ct_o
);
    localparam int QW  = BLK_W / 4;
    localparam int ROT = 61;

    logic [BLK_W-1:0] mixed;
    logic [BLK_W-1:0] subst;
    logic [KEY_W-1:0] rot;

    assign mixed = st_i ^ rk_i[KEY_W-1 -: BLK_W];

    prst_sbox_layer #(.W(BLK_W)) u_sbox (
        .d_i (mixed),
        .q_o (subst)
    );

    // bit permutation: bit i moves to position QW*(i mod 4) + i/4
    for (genvar i = 0; i < BLK_W; i++) begin : g_perm
        assign st_o[QW*(i%4) + (i/4)] = subst[i];
    end

    always_comb begin
        rot  = {rk_i[KEY_W-ROT-1:0], rk_i[KEY_W-1:KEY_W-ROT]};
        rk_o = rot;
        rk_o[KEY_W-1 -: prst_pkg::NIB]              = prst_pkg::sbox4(rot[KEY_W-1 -: prst_pkg::NIB]);
        rk_o[KEY_W-1-prst_pkg::NIB -: prst_pkg::NIB] =
            prst_pkg::sbox4(rot[KEY_W-1-prst_pkg::NIB -: prst_pkg::NIB]);
        rk_o[RC_LO +: RC_W] = rot[RC_LO +: RC_W] ^ rc_i;
    end

    assign ct_o = st_o ^ rk_o[KEY_W-1 -: BLK_W];
endmodule

// File: rtl/prst_digest.sv
module prst_digest
    import prst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             scramble_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [BLK_W-1:0] data_i,
    input  logic             data_valid_i,
    input  logic             data_last_i,
    output logic             data_ready_o,
    output logic [BLK_W-1:0] digest_o,
    output logic             done_o
);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(NROUNDS);
    localparam int              PAD_W   = KEY_W - BLK_W;

    phase_e           phase;
    job_e             job;
    logic [BLK_W-1:0] chain;
    logic [BLK_W-1:0] st;
    logic [KEY_W-1:0] rk;
    logic [RC_W-1:0]  rc;
    logic [BLK_W-1:0] lo_half;
    logic             half_sel;
    logic             last_seen;
    logic [KEY_W-1:0] fconst;

    logic [BLK_W-1:0] rnd_st;
    logic [KEY_W-1:0] rnd_rk;
    logic [BLK_W-1:0] rnd_ct;

    prst_round u_round (
        .st_i (st),
        .rk_i (rk),
        .rc_i (rc),
        .st_o (rnd_st),
        .rk_o (rnd_rk),
        .ct_o (rnd_ct)
    );

    assign data_ready_o = (phase == PH_COLLECT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            job       <= JOB_SCRAMBLE;
            chain     <= '0;
            st        <= '0;
            rk        <= '0;
            rc        <= '0;
            lo_half   <= '0;
            half_sel  <= 1'b0;
            last_seen <= 1'b0;
            fconst    <= '0;
            digest_o  <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        chain    <= blk_i;
                        st       <= blk_i;
                        fconst   <= key_i;
                        half_sel <= 1'b0;
                        if (scramble_i) begin
                            rk    <= key_i;
                            rc    <= RC_W'(1);
                            job   <= JOB_SCRAMBLE;
                            phase <= PH_RUN;
                        end else begin
                            phase <= PH_COLLECT;
                        end
                    end
                end
                PH_COLLECT: begin
                    if (data_valid_i) begin
                        if (!half_sel && !data_last_i) begin
                            lo_half  <= data_i;
                            half_sel <= 1'b1;
                        end else begin
                            rk        <= half_sel ? {data_i, lo_half} : {{PAD_W{1'b0}}, data_i};
                            st        <= chain;
                            rc        <= RC_W'(1);
                            job       <= JOB_CHUNK;
                            last_seen <= data_last_i;
                            half_sel  <= 1'b0;
                            phase     <= PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    st <= rnd_st;
                    rk <= rnd_rk;
                    rc <= rc + RC_W'(1);
                    if (rc == RC_LAST) begin
                        case (job)
                            JOB_SCRAMBLE: begin
                                digest_o <= rnd_ct;
                                done_o   <= 1'b1;
                                phase    <= PH_IDLE;
                            end
                            JOB_CHUNK: begin
                                chain <= rnd_ct ^ chain;
                                if (last_seen) begin
                                    st    <= rnd_ct ^ chain;
                                    rk    <= fconst;
                                    rc    <= RC_W'(1);
                                    job   <= JOB_FINAL;
                                end else begin
                                    phase <= PH_COLLECT;
                                end
                            end
                            default: begin
                                digest_o <= rnd_ct ^ chain;
                                done_o   <= 1'b1;
                                phase    <= PH_IDLE;
                            end
                        endcase
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2
    digest_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(digest_o));

    // R1
    round_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && rc != RC_LAST) |=> (rc == $past(rc) + RC_W'(1)));

    // R6
    chunk_close_chk: assert property (@(posedge clk) disable iff (rst)
        (data_valid_i && data_ready_o && (half_sel || data_last_i)) |=> !data_ready_o);

    // R3
    chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COLLECT && !data_valid_i) |=> $stable(chain));

endmodule

// File: tb/tb_prst_digest.sv
module tb_prst_digest;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic         scramble_i;
    logic [63:0]  blk_i;
    logic [127:0] key_i;
    logic [63:0]  data_i;
    logic         data_valid_i;
    logic         data_last_i;
    logic         data_ready_o;
    logic [63:0]  digest_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;

    logic [63:0] beats [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    prst_digest dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .scramble_i   (scramble_i),
        .blk_i        (blk_i),
        .key_i        (key_i),
        .data_i       (data_i),
        .data_valid_i (data_valid_i),
        .data_last_i  (data_last_i),
        .data_ready_o (data_ready_o),
        .digest_o     (digest_o),
        .done_o       (done_o)
    );

    // ---------------- reference model ----------------
    localparam logic [63:0] SB_TAB = 64'h21748FE3DA09B65C;

    function automatic logic [3:0] m_sb(input logic [3:0] x);
        return SB_TAB[x*4 +: 4];
    endfunction

    function automatic logic [63:0] m_enc(input logic [63:0] pt, input logic [127:0] key);
        logic [63:0]  s;
        logic [63:0]  p;
        logic [127:0] k;
        s = pt;
        k = key;
        for (int r = 1; r <= 31; r++) begin
            s = s ^ k[127:64];
            for (int n = 0; n < 16; n++) s[n*4 +: 4] = m_sb(s[n*4 +: 4]);
            for (int b = 0; b < 64; b++) p[(b == 63) ? 63 : ((b*16) % 63)] = s[b];
            s = p;
            k = {k[66:0], k[127:67]};
            k[127:124] = m_sb(k[127:124]);
            k[123:120] = m_sb(k[123:120]);
            k[66:62]   = k[66:62] ^ 5'(r);
        end
        return s ^ k[127:64];
    endfunction

    function automatic logic [63:0] m_digest(input logic [63:0] iv, input logic [127:0] fc, input int n);
        logic [63:0] c;
        logic [63:0] hi;
        int i;
        c = iv;
        i = 0;
        while (i < n) begin
            if (i + 1 < n) hi = beats[i+1];
            else           hi = '0;
            c = m_enc(c, {hi, beats[i]}) ^ c;
            i = i + 2;
        end
        return m_enc(c, fc) ^ c;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start_i = 0; scramble_i = 0; blk_i = '0; key_i = '0;
        data_i = '0; data_valid_i = 0; data_last_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset();
        chk(done_o == 1'b0,       "R7", "done after reset",   128'(done_o), 128'(0));
        chk(data_ready_o == 1'b0, "R7", "ready after reset",  128'(data_ready_o), 128'(0));
        chk(digest_o == '0,       "R7", "digest after reset", 128'(digest_o), 128'(0));
    endtask

    task automatic run_scramble(input logic [63:0] pt, input logic [127:0] key,
                                input logic [63:0] exp, input bit check_lat);
        int cnt;
        logic [63:0] held;
        @(negedge clk);
        start_i = 1; scramble_i = 1; blk_i = pt; key_i = key;
        @(negedge clk);
        start_i = 0; scramble_i = 0;
        cnt = 0;
        while (!done_o && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        chk(digest_o == exp, "R1", "scramble result", 128'(digest_o), 128'(exp));
        if (check_lat)
            chk(cnt == 31, "R2", "scramble latency", 128'(cnt), 128'(31));
        held = digest_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R2", "done single cycle", 128'(done_o), 128'(0));
        repeat (3) @(negedge clk);
        chk(digest_o == held, "R2", "digest held", 128'(digest_o), 128'(held));
    endtask

    task automatic run_digest(input logic [63:0] iv, input logic [127:0] fc, input int n,
                              input bit junk, input bit restart, input string req,
                              output logic [63:0] got);
        int cnt;
        logic [63:0] exp;
        exp = m_digest(iv, fc, n);
        @(negedge clk);
        start_i = 1; scramble_i = 0; blk_i = iv; key_i = fc;
        @(negedge clk);
        start_i = 0;
        for (int b = 0; b < n; b++) begin
            cnt = 0;
            while (!data_ready_o && cnt < 200) begin
                if (junk) begin
                    data_valid_i = 1; data_i = 64'hDEAD_BEEF_0BAD_F00D; data_last_i = 1;
                end
                @(negedge clk);
                cnt++;
            end
            data_valid_i = 1; data_i = beats[b]; data_last_i = (b == n-1);
            if (restart && b == 0) begin
                start_i = 1; scramble_i = 1; blk_i = ~iv; key_i = ~fc;
            end
            @(negedge clk);
            data_valid_i = 0; data_last_i = 0; start_i = 0; scramble_i = 0;
        end
        cnt = 0;
        while (!done_o && cnt < 400) begin
            if (junk) begin
                chk(data_ready_o == 1'b0, "R6", "ready low while busy", 128'(data_ready_o), 128'(0));
                data_valid_i = 1; data_i = 64'h1234_5678_9ABC_DEF0; data_last_i = 1;
            end
            @(negedge clk);
            cnt++;
        end
        data_valid_i = 0; data_last_i = 0;
        chk(done_o == 1'b1, "R5", "digest done seen", 128'(done_o), 128'(1));
        chk(digest_o == exp, req, "digest value", 128'(digest_o), 128'(exp));
        got = digest_o;
        @(negedge clk);
        chk(data_ready_o == 1'b0, "R6", "ready low when idle", 128'(data_ready_o), 128'(0));
    endtask

    // ---------------- scenarios ----------------
    task automatic test_vector();
        // R1: published all-zero vector
        chk(m_enc('0, '0) == 64'h96db702a2e6900af, "R1", "model sanity",
            128'(m_enc('0, '0)), 128'(64'h96db702a2e6900af));
        run_scramble('0, '0, 64'h96db702a2e6900af, 1'b1);
    endtask

    task automatic test_scramble_mix();
        // R1 with non-trivial operands
        logic [63:0]  pt  = 64'h0123_4567_89AB_CDEF;
        logic [127:0] key = 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978;
        run_scramble(pt, key, m_enc(pt, key), 1'b0);
        run_scramble('1, '1, m_enc('1, '1), 1'b1);
    endtask

    task automatic test_digest_full();
        // R3 R5: two full chunks
        logic [63:0] g;
        beats[0] = 64'h1111_2222_3333_4444; beats[1] = 64'h5555_6666_7777_8888;
        beats[2] = 64'h9999_AAAA_BBBB_CCCC; beats[3] = 64'hDDDD_EEEE_FFFF_0000;
        run_digest(64'hA5A5_5A5A_C3C3_3C3C, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF,
                   4, 1'b0, 1'b0, "R3", g);
    endtask

    task automatic test_digest_partial();
        // R4: half chunk equals explicit zero upper beat
        logic [63:0] g1;
        logic [63:0] g2;
        beats[0] = 64'hCAFE_F00D_1234_5678;
        run_digest(64'h0F0F_0F0F_F0F0_F0F0, 128'h1, 1, 1'b0, 1'b0, "R4", g1);
        beats[1] = '0;
        run_digest(64'h0F0F_0F0F_F0F0_F0F0, 128'h1, 2, 1'b0, 1'b0, "R4", g2);
        chk(g1 == g2, "R4", "padding equivalence", 128'(g1), 128'(g2));
        // R4: odd beat count after a full chunk
        beats[0] = 64'h1; beats[1] = 64'h2; beats[2] = 64'h3;
        run_digest(64'h0, 128'hFFFF, 3, 1'b0, 1'b0, "R4", g1);
    endtask

    task automatic test_busy_junk();
        // R6: beats offered while not ready have no effect
        logic [63:0] g;
        beats[0] = 64'hAAAA_0000_BBBB_1111; beats[1] = 64'hCCCC_2222_DDDD_3333;
        beats[2] = 64'hEEEE_4444_FFFF_5555; beats[3] = 64'h0101_0202_0303_0404;
        beats[4] = 64'h7777_7777_7777_7777;
        run_digest(64'h1357_9BDF_2468_ACE0, 128'h8000_0000_0000_0000_0000_0000_0000_0001,
                   5, 1'b1, 1'b0, "R6", g);
    endtask

    task automatic test_restart_ignored();
        // R8: start pulse during collection is ignored
        logic [63:0] g;
        beats[0] = 64'h0BAD_CAFE_0BAD_CAFE; beats[1] = 64'h600D_600D_600D_600D;
        run_digest(64'h2222_4444_6666_8888, 128'h3, 2, 1'b0, 1'b1, "R8", g);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_vector();
        test_scramble_mix();
        test_digest_full();
        test_digest_partial();
        test_busy_junk();
        test_restart_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule